// File: doc/BRIEF.md
# Sign-Magnitude Result Display Driver

This block takes the 4-bit result of a small ALU and shows it to a person. In logic mode the four result bits go straight to four discrete LEDs, and the seven-segment digits stay dark. In arithmetic mode the result is treated as a two's complement number. It is split into a sign and a magnitude, and both are shown on seven-segment digits.

The magnitude digit and the sign digit share one active-low segment bus. A clock divider toggles a select at twice the refresh rate, so each of the two digits is lit for half of every refresh period. The divider ratio is computed from the system clock frequency. The two leftmost digits of the four-digit group are always held dark.

Top module: `result_display`

## Requirements
- R1: When `arith_mode_i` is 0, `led_o` equals `result_i`, every bit of `dig_en_n_o` is 1 (all digits off) and `seg_n_o` is 7'b1111111.
- R2: When `arith_mode_i` is 1, `led_o` is 4'b0000.
- R3: The segment bus is active-low, with bit 6 = segment a and bit 0 = segment g. The magnitude glyphs are 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111 and 8=0000000. For a non-negative result (bit 3 clear), the magnitude digit shows the result value.
- R4: For a negative result (bit 3 set), the magnitude digit shows the two's complement negation, so 1000 shows 8 and 1010 shows 6.
- R5: The sign digit shows 1111110 (minus, segment g only) for a negative result and 1111111 (blank) otherwise.
- R6: In arithmetic mode, when the select is high the sign glyph is on `seg_n_o` and only `dig_en_n_o[1]` is 0. When the select is low the magnitude glyph is on the bus and only `dig_en_n_o[0]` is 0. The enables are active-low.
- R7: `dig_en_n_o` bits 2 and above are 1 at all times.
- R8: The select holds for exactly CLK_HZ/(2*REFRESH_HZ) clock cycles between toggles.
- R9: While reset is asserted, the select is low, so in arithmetic mode the magnitude digit (`dig_en_n_o` = 4'b1110) is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arith_mode_i | input | 1 | 1 = arithmetic result, 0 = logic result |
| result_i | input | 4 | ALU result |
| led_o | output | 4 | Discrete LEDs, active-high |
| seg_n_o | output | 7 | Shared segment bus, active-low, a..g from MSB |
| dig_en_n_o | output | NUM_DIGITS | Digit enables, active-low; bit 0 magnitude, bit 1 sign |

## Verification
The hardest case to reach is seeing both digits of one result, because only one digit is ever on the shared bus and the visible digit depends on the free-running divider phase. For each result value, the stimulus waits on the digit enables for the magnitude phase and then for the sign phase, and samples the bus in each phase. The divider is built with a small clock-frequency parameter, so a full sweep of all sixteen codes and the measurement of the toggle interval fit in a short run.

// File: rtl/resdisp_pkg.sv
package resdisp_pkg;
  localparam int RES_W = 4;
  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_BLANK = 7'b1111111;
  localparam seg_t SEG_MINUS = 7'b1111110;

  // active-low glyphs, bit 6 = a ... bit 0 = g
  function automatic seg_t digit_glyph(input logic [RES_W-1:0] d);
    seg_t g;
    case (d)
      4'd0:    g = 7'b0000001;
      4'd1:    g = 7'b1001111;
      4'd2:    g = 7'b0010010;
      4'd3:    g = 7'b0000110;
      4'd4:    g = 7'b1001100;
      4'd5:    g = 7'b0100100;
      4'd6:    g = 7'b0100000;
      4'd7:    g = 7'b0001111;
      4'd8:    g = 7'b0000000;
      4'd9:    g = 7'b0000100;
      default: g = SEG_BLANK;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/refresh_divider.sv
module refresh_divider #(
  parameter int DIV_CNT = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic sel_o
);
  localparam int CNT_W = (DIV_CNT < 2) ? 1 : $clog2(DIV_CNT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_CNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sel_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    sel_d = wrap ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  p_toggle_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (sel_q != $past(sel_q)));
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(sel_q));
endmodule

// File: rtl/sm_convert.sv
module sm_convert
  import resdisp_pkg::*;
(
  input  logic [RES_W-1:0] value_i,
  output logic             neg_o,
  output logic [RES_W-1:0] mag_o
);
  always_comb begin
    neg_o = value_i[RES_W-1];
    mag_o = neg_o ? (~value_i + 1'b1) : value_i;
  end

  always_comb begin
    if (value_i == 4'b1000)
      a_min_is_eight_r4: assert (neg_o && mag_o == 4'd8);
  end
endmodule

// File: rtl/seg_mux.sv
module seg_mux
  import resdisp_pkg::*;
(
  input  logic             active_i,
  input  logic             show_sign_i,
  input  logic             neg_i,
  input  logic [RES_W-1:0] mag_i,
  output seg_t             seg_n_o
);
  seg_t sign_glyph, mag_glyph;

  always_comb begin
    sign_glyph = neg_i ? SEG_MINUS : SEG_BLANK;
    mag_glyph  = digit_glyph(mag_i);
    if (!active_i)        seg_n_o = SEG_BLANK;
    else if (show_sign_i) seg_n_o = sign_glyph;
    else                  seg_n_o = mag_glyph;
  end
endmodule

// File: rtl/result_display.sv
module result_display
  import resdisp_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int REFRESH_HZ = 490,
  parameter int NUM_DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arith_mode_i,
  input  logic [RES_W-1:0]      result_i,
  output logic [RES_W-1:0]      led_o,
  output logic [SEG_W-1:0]      seg_n_o,
  output logic [NUM_DIGITS-1:0] dig_en_n_o
);
  localparam int RAW_DIV = CLK_HZ / (2 * REFRESH_HZ);
  localparam int DIV_CNT = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int MAG_DIG  = 0;
  localparam int SIGN_DIG = 1;

  // reset synchroniser: asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             sel;
  logic             neg;
  logic [RES_W-1:0] mag;

  refresh_divider #(.DIV_CNT(DIV_CNT)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel_o (sel)
  );

  sm_convert u_conv (
    .value_i (result_i),
    .neg_o   (neg),
    .mag_o   (mag)
  );

  seg_mux u_seg (
    .active_i    (arith_mode_i),
    .show_sign_i (sel),
    .neg_i       (neg),
    .mag_i       (mag),
    .seg_n_o     (seg_n_o)
  );

  assign led_o = arith_mode_i ? '0 : result_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    if (i == MAG_DIG) begin : g_mag
      assign dig_en_n_o[i] = ~(arith_mode_i & ~sel);
    end else if (i == SIGN_DIG) begin : g_sign
      assign dig_en_n_o[i] = ~(arith_mode_i & sel);
    end else begin : g_off
      assign dig_en_n_o[i] = 1'b1;
    end
  end

  p_logic_dark_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !arith_mode_i |-> (&dig_en_n_o && seg_n_o == SEG_BLANK));
  p_one_digit_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(~dig_en_n_o) <= 1);
  p_minus_on_sign_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!dig_en_n_o[SIGN_DIG] && result_i[RES_W-1]) |-> seg_n_o == SEG_MINUS);
  p_left_off_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    &dig_en_n_o[NUM_DIGITS-1:2]);
endmodule

// File: tb/result_display_bench.sv
module result_display_bench;
  localparam int CLK_HZ = 9800;
  localparam int REF_HZ = 490;
  localparam int DIV    = CLK_HZ / (2 * REF_HZ);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arith = 1'b0;
  logic [3:0] res = 4'd0;
  logic [3:0] led;
  logic [6:0] seg;
  logic [3:0] den;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  result_display #(.CLK_HZ(CLK_HZ), .REFRESH_HZ(REF_HZ), .NUM_DIGITS(4)) u_result_display (
    .clk(clk), .rst_n(rst_n), .arith_mode_i(arith), .result_i(res),
    .led_o(led), .seg_n_o(seg), .dig_en_n_o(den)
  );

  function automatic logic [6:0] exp_glyph(input int d);
    case (d)
      0: return 7'b0000001; 1: return 7'b1001111; 2: return 7'b0010010;
      3: return 7'b0000110; 4: return 7'b1001100; 5: return 7'b0100100;
      6: return 7'b0100000; 7: return 7'b0001111; 8: return 7'b0000000;
      default: return 7'b1111111;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_digit(input int idx);
    for (int n = 0; n < 4 * DIV; n++) begin
      @(negedge clk);
      if (den[idx] === 1'b0) return;
    end
  endtask

  task automatic t_reset;
    arith = 1'b1; res = 4'd3;
    repeat (3) @(negedge clk);
    check("R9 enables in reset", 16'(den), 16'h000E);
    check("R3 magnitude in reset", 16'(seg), 16'(exp_glyph(3)));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_logic;
    logic [3:0] pats [3] = '{4'b1010, 4'b0101, 4'b1111};
    arith = 1'b0;
    foreach (pats[k]) begin
      res = pats[k];
      @(negedge clk);
      check("R1 leds", 16'(led), 16'(pats[k]));
      check("R1 enables off", 16'(den), 16'h000F);
      check("R1 segments blank", 16'(seg), 16'h007F);
    end
  endtask

  task automatic t_arith_sweep;
    arith = 1'b1;
    for (int v = 0; v < 16; v++) begin
      int m;
      res = 4'(v);
      m = (v < 8) ? v : 16 - v;
      wait_digit(0);
      check(v < 8 ? "R3 magnitude" : "R4 negative magnitude", 16'(seg), 16'(exp_glyph(m)));
      check("R6 magnitude enables", 16'(den), 16'h000E);
      check("R2 leds dark", 16'(led), 16'h0000);
      wait_digit(1);
      check("R5 sign glyph", 16'(seg), (v < 8) ? 16'h007F : 16'h007E);
      check("R7 R6 sign enables", 16'(den), 16'h000D);
    end
  endtask

  task automatic t_period;
    logic prev;
    int n;
    arith = 1'b1; res = 4'd5;
    wait_digit(1);
    wait_digit(0);
    for (int k = 0; k < 2; k++) begin
      prev = den[0];
      n = 0;
      while (den[0] === prev && n < 4 * DIV) begin
        @(negedge clk);
        n++;
      end
      check("R8 select interval", 16'(n), 16'(DIV));
    end
  endtask

  initial begin
    t_reset();
    t_logic();
    t_arith_sweep();
    t_period();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule